// File: doc/BRIEF.md
# Conditional Call, Return and Restart Sequencer

This block is the slice of an 8-bit processor's control path that carries out subroutine transfers: the conditional call, the plain return, the conditional return and the single-byte restart. The decoder hands over an operation code, a 3-bit field and the flag byte with a one-cycle start pulse. The block then steps through the machine cycles of that operation, one clock per T-state. It drives a byte-wide memory port, evaluates the condition against the flags itself, and updates the program counter and stack pointer it holds.

The memory port carries an address, write data, read data, a read strobe and a write strobe. The read strobe covers the whole of a read machine cycle, and read data must be valid within the same T-state. The write strobe is a single-clock pulse in the last T-state of a write machine cycle. Opcode fetch is not performed here. The first machine cycle only accounts for its T-states, and PC points at the opcode when start is given. The T-state counter makes the cycle cost of each path visible so timing can be checked at the port.

Top module: `subr_flow_seq`

## Requirements
- R1: A synchronous active-high reset sets PC to 0000h and SP to FFFFh, clears the T-state count, and leaves busy and done low.
- R2: The field selects a condition from the flag byte (S = bit 7, Z = bit 6, P/V = bit 2, C = bit 0). The codes are: 000 Z clear, 001 Z set, 010 C clear, 011 C set, 100 P/V clear, 101 P/V set, 110 S clear, 111 S set. The other flag bits have no effect.
- R3: Operation 00 (conditional call) with a true condition reads the target low byte at PC+1 and the high byte at PC+2. It then writes the high byte of PC+3 to SP-1, and after that the low byte to SP-2. It ends with SP lowered by 2 and PC equal to the target.
- R4: A conditional call with a false condition makes no memory write, leaves SP unchanged and sets PC to PC+3.
- R5: Operation 01 (return) loads PC low from (SP) and PC high from (SP+1), and raises SP by 2.
- R6: Operation 10 (conditional return) behaves as R5 when its condition is true. When it is false, it makes no memory access, leaves SP unchanged and sets PC to PC+1.
- R7: Operation 11 (restart) pushes PC+1 in the order given in R3 and loads PC with 00h in the high byte and the field times 8 in the low byte.
- R8: The T-state totals are 17 (4,3,4,3,3) for a taken call and 10 for a call not taken, 10 for a return, 11 (5,3,3) for a taken conditional return and 5 for one not taken, and 11 for a restart. The count reads 1 in the first T-state, equals the total in the last one, and holds it until the next start.
- R9: busy is high from the clock after the accepted start through the final T-state. done is high for exactly that final T-state.
- R10: A start pulse while busy is ignored. The running operation completes with its own operation, field and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins an operation when idle |
| op | input | 2 | Operation: 00 call cc, 01 return, 10 return cc, 11 restart |
| field | input | 3 | Condition code or restart index |
| flags | input | 8 | Flag byte, read only |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the same T-state |
| mem_rd | output | 1 | Read strobe, high for a whole read machine cycle |
| mem_wr | output | 1 | Write strobe, one clock in the last T-state of a write |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final T-state of the operation |
| tcount | output | 5 | T-states of the current or last operation |

## Verification
Start is sampled at one clock edge. The first T-state follows, and done rises in the clock that is T-state number 5, 10, 11 or 17 from then. The T-state count equals that total in the same clock, and PC, SP and the stack bytes take their new values at the edge that closes the done cycle. The bench drives inputs and samples outputs on falling edges. It counts busy clocks until done is seen, checks the count there, and then moves one more falling edge before comparing PC, SP, the memory bytes written and the write count with its own model. Condition codes are swept over all eight fields and all sixteen combinations of the four tested flags, for both calls and conditional returns.

// File: rtl/subr_seq_pkg.sv
`timescale 1ns/1ps
package subr_seq_pkg;

   typedef enum logic [1:0] {
      OP_CALLC = 2'b00,
      OP_RET   = 2'b01,
      OP_RETC  = 2'b10,
      OP_RST   = 2'b11
   } flow_op_e;

   typedef enum logic [2:0] {
      MC_IDLE,
      MC_OP,
      MC_RDLO,
      MC_RDHI,
      MC_WRHI,
      MC_WRLO
   } mcyc_e;

endpackage

// File: rtl/flow_cond.sv
`timescale 1ns/1ps
module flow_cond #(
   parameter int DW     = 8,
   parameter int S_BIT  = 7,
   parameter int Z_BIT  = 6,
   parameter int PV_BIT = 2,
   parameter int C_BIT  = 0
) (
   input  logic [2:0]    field,
   input  logic [DW-1:0] flags,
   output logic          ok
);
   if (S_BIT >= DW || Z_BIT >= DW || PV_BIT >= DW || C_BIT >= DW) begin : g_bad_bit
      $error("flow_cond: flag position outside the flag byte");
   end

   logic picked;
   logic unused_flag_bits;

   // field[2:1] chooses the flag, field[0] chooses its polarity
   always_comb begin
      unique case (field[2:1])
         2'b00:   picked = flags[Z_BIT];
         2'b01:   picked = flags[C_BIT];
         2'b10:   picked = flags[PV_BIT];
         default: picked = flags[S_BIT];
      endcase
      ok = field[0] ? picked : ~picked;
   end

   assign unused_flag_bits = ^flags;
endmodule

// File: rtl/flow_fsm.sv
`timescale 1ns/1ps
module flow_fsm
   import subr_seq_pkg::*;
#(
   parameter int TCW = 5
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           start,
   input  flow_op_e       op,
   input  logic           taken,
   output mcyc_e          mc,
   output logic           last_t,
   output logic           done,
   output logic           busy,
   output logic [TCW-1:0] tcount
);
   if (TCW < 5) begin : g_bad_tcw
      $error("flow_fsm: counter too narrow for 17 T-states");
   end

   localparam logic [2:0] LEN_SHORT = 3'd3;
   localparam logic [2:0] LEN_MID   = 3'd4;
   localparam logic [2:0] LEN_LONG  = 3'd5;

   logic [2:0] tin;
   logic [2:0] len;
   mcyc_e      nxt;

   always_comb begin
      unique case (mc)
         MC_OP:   len = (op == OP_RETC || op == OP_RST) ? LEN_LONG : LEN_MID;
         MC_RDHI: len = (op == OP_CALLC && taken) ? LEN_MID : LEN_SHORT;
         default: len = LEN_SHORT;
      endcase
      unique case (mc)
         MC_OP: begin
            if (op == OP_RST)                 nxt = MC_WRHI;
            else if (op == OP_RETC && !taken) nxt = MC_IDLE;
            else                              nxt = MC_RDLO;
         end
         MC_RDLO: nxt = MC_RDHI;
         MC_RDHI: nxt = (op == OP_CALLC && taken) ? MC_WRHI : MC_IDLE;
         MC_WRHI: nxt = MC_WRLO;
         default: nxt = MC_IDLE;
      endcase
   end

   assign busy   = (mc != MC_IDLE);
   assign last_t = busy && (tin == len - 3'd1);
   assign done   = last_t && (nxt == MC_IDLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         mc     <= MC_IDLE;
         tin    <= '0;
         tcount <= '0;
      end else if (mc == MC_IDLE) begin
         if (start) begin
            mc     <= MC_OP;
            tin    <= '0;
            tcount <= TCW'(1);
         end
      end else begin
         if (!done) tcount <= tcount + TCW'(1);
         if (last_t) begin
            mc  <= nxt;
            tin <= '0;
         end else begin
            tin <= tin + 3'd1;
         end
      end
   end

   a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   a_r9_idle_after_done: assert property (@(posedge clk) disable iff (rst)
      done |=> !busy);
   a_r8_legal_total: assert property (@(posedge clk) disable iff (rst)
      done |-> (tcount == TCW'(5) || tcount == TCW'(10) ||
                tcount == TCW'(11) || tcount == TCW'(17)));
   a_r6_short_return: assert property (@(posedge clk) disable iff (rst)
      (done && op == OP_RETC && !taken) |-> tcount == TCW'(5));
endmodule

// File: rtl/subr_flow_seq.sv
`timescale 1ns/1ps
module subr_flow_seq
   import subr_seq_pkg::*;
#(
   parameter int AW         = 16,
   parameter int DW         = 8,
   parameter int TCW        = 5,
   parameter int RST_STRIDE = 8,
   parameter int S_BIT      = 7,
   parameter int Z_BIT      = 6,
   parameter int PV_BIT     = 2,
   parameter int C_BIT      = 0
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           start,
   input  logic [1:0]     op,
   input  logic [2:0]     field,
   input  logic [DW-1:0]  flags,
   output logic [AW-1:0]  mem_addr,
   output logic [DW-1:0]  mem_wdata,
   input  logic [DW-1:0]  mem_rdata,
   output logic           mem_rd,
   output logic           mem_wr,
   output logic [AW-1:0]  pc,
   output logic [AW-1:0]  sp,
   output logic           busy,
   output logic           done,
   output logic [TCW-1:0] tcount
);
   localparam logic [AW-1:0] ONE   = AW'(1);
   localparam logic [AW-1:0] TWO   = AW'(2);
   localparam logic [AW-1:0] THREE = AW'(3);
   localparam int            VEC_MAX = RST_STRIDE * 7;

   if (AW != 2 * DW) begin : g_bad_aw
      $error("subr_flow_seq: address must be two data bytes wide");
   end
   if (RST_STRIDE < 1 || VEC_MAX >= (1 << DW)) begin : g_bad_stride
      $error("subr_flow_seq: restart vectors must stay in page zero");
   end

   flow_op_e      op_q;
   logic [2:0]    fld_q;
   logic [DW-1:0] flg_q;
   logic [DW-1:0] lo_q, hi_q;
   logic          cond_ok, taken, last_t;
   mcyc_e         mc;
   logic [AW-1:0] ret_addr, rst_vec;

   flow_cond #(.DW(DW), .S_BIT(S_BIT), .Z_BIT(Z_BIT), .PV_BIT(PV_BIT), .C_BIT(C_BIT)) u_cond (
      .field (fld_q),
      .flags (flg_q),
      .ok    (cond_ok)
   );

   assign taken = (op_q == OP_CALLC || op_q == OP_RETC) ? cond_ok : 1'b1;

   flow_fsm #(.TCW(TCW)) u_fsm (
      .clk    (clk),
      .rst    (rst),
      .start  (start),
      .op     (op_q),
      .taken  (taken),
      .mc     (mc),
      .last_t (last_t),
      .done   (done),
      .busy   (busy),
      .tcount (tcount)
   );

   if ((RST_STRIDE & (RST_STRIDE - 1)) == 0) begin : g_vec_shift
      assign rst_vec = AW'(fld_q) << $clog2(RST_STRIDE);
   end else begin : g_vec_mul
      assign rst_vec = AW'(fld_q) * AW'(RST_STRIDE);
   end

   assign ret_addr = pc + ((op_q == OP_CALLC) ? THREE : ONE);

   // memory port per machine cycle
   always_comb begin
      mem_addr  = pc;
      mem_wdata = '0;
      unique case (mc)
         MC_RDLO: mem_addr = (op_q == OP_CALLC) ? pc + ONE : sp;
         MC_RDHI: mem_addr = (op_q == OP_CALLC) ? pc + TWO : sp + ONE;
         MC_WRHI: begin
            mem_addr  = sp - ONE;
            mem_wdata = ret_addr[AW-1:DW];
         end
         MC_WRLO: begin
            mem_addr  = sp - TWO;
            mem_wdata = ret_addr[DW-1:0];
         end
         default: ;
      endcase
   end

   assign mem_rd = (mc == MC_RDLO) || (mc == MC_RDHI);
   assign mem_wr = last_t && ((mc == MC_WRHI) || (mc == MC_WRLO));

   always_ff @(posedge clk) begin
      if (rst) begin
         pc    <= '0;
         sp    <= '1;
         op_q  <= OP_CALLC;
         fld_q <= '0;
         flg_q <= '0;
         lo_q  <= '0;
         hi_q  <= '0;
      end else begin
         if (!busy && start) begin
            op_q  <= flow_op_e'(op);
            fld_q <= field;
            flg_q <= flags;
         end
         if (last_t) begin
            unique case (mc)
               MC_OP:   if (op_q == OP_RETC && !taken) pc <= pc + ONE;
               MC_RDLO: lo_q <= mem_rdata;
               MC_RDHI: begin
                  if (op_q == OP_CALLC) begin
                     if (taken) hi_q <= mem_rdata;
                     else       pc   <= pc + THREE;
                  end else begin
                     pc <= {mem_rdata, lo_q};
                     sp <= sp + TWO;
                  end
               end
               MC_WRLO: begin
                  sp <= sp - TWO;
                  pc <= (op_q == OP_CALLC) ? {hi_q, lo_q} : rst_vec;
               end
               default: ;
            endcase
         end
      end
   end

   a_r10_hold_operands: assert property (@(posedge clk) disable iff (rst)
      busy |=> ($stable(op_q) && $stable(fld_q) && $stable(flg_q)));
   a_r4_no_write_untaken: assert property (@(posedge clk) disable iff (rst)
      (busy && op_q == OP_CALLC && !taken) |-> !mem_wr);
   a_r3_strobe_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));
   a_r3_high_then_low: assert property (@(posedge clk) disable iff (rst)
      (mem_wr && mc == MC_WRLO) |-> ($past(mem_wr, 3) && $past(mem_addr, 3) == mem_addr + ONE));
   a_r5_pop_raises_sp: assert property (@(posedge clk) disable iff (rst)
      (done && mc == MC_RDHI && op_q != OP_CALLC) |=> sp == $past(sp) + TWO);
   a_r7_page_zero: assert property (@(posedge clk) disable iff (rst)
      (done && op_q == OP_RST) |=> pc[AW-1:DW] == '0);
endmodule

// File: tb/subr_flow_seq_test.sv
`timescale 1ns/1ps
module subr_flow_seq_test;
   logic        clk = 1'b0;
   logic        rst;
   logic        start;
   logic [1:0]  op_i;
   logic [2:0]  fld_i;
   logic [7:0]  flags_i;
   logic [15:0] mem_addr, pc, sp;
   logic [7:0]  mem_wdata, mem_rdata;
   logic        mem_rd, mem_wr, busy, done;
   logic [4:0]  tcount;

   int n_tests = 0;
   int n_fail  = 0;
   int wr_cnt  = 0;
   int n_tgt   = 0;
   bit ended   = 0;
   logic [15:0] pc_m, sp_m;
   logic [7:0]  mem [0:4095];

   always #10 clk = ~clk;

   subr_flow_seq uut (
      .clk(clk), .rst(rst), .start(start), .op(op_i), .field(fld_i), .flags(flags_i),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .pc(pc), .sp(sp),
      .busy(busy), .done(done), .tcount(tcount)
   );

   assign mem_rdata = mem[mem_addr[11:0]];
   always @(posedge clk) begin
      if (mem_wr) begin
         mem[mem_addr[11:0]] <= mem_wdata;
         wr_cnt <= wr_cnt + 1;
      end
   end

   function automatic int a12(input logic [15:0] a);
      return int'(a[11:0]);
   endfunction

   // R2: condition table
   function automatic bit cond_ok(input logic [2:0] f, input logic [7:0] fl);
      case (f)
         3'd0: return !fl[6];
         3'd1: return fl[6];
         3'd2: return !fl[0];
         3'd3: return fl[0];
         3'd4: return !fl[2];
         3'd5: return fl[2];
         3'd6: return !fl[7];
         default: return fl[7];
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   task automatic run_op(input logic [1:0] o, input logic [2:0] f, input logic [7:0] fl,
                         input int exp_t, input bit inject, input string tag);
      int nb = 0;
      int guard = 0;
      @(negedge clk);
      op_i = o; fld_i = f; flags_i = fl; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (done !== 1'b1 && guard < 40) begin
         if (busy === 1'b1) nb++;
         if (inject && nb == 3) begin
            start = 1'b1; op_i = 2'b11; fld_i = 3'd7;   // R10 stray start
         end else begin
            start = 1'b0;
         end
         guard++;
         @(negedge clk);
      end
      start = 1'b0;
      if (busy === 1'b1) nb++;
      chk({"R8 T-state total ", tag}, 32'(tcount), 32'(exp_t));
      chk({"R9 busy span ", tag}, 32'(nb), 32'(exp_t));
      @(negedge clk);
      chk({"R9 done one cycle ", tag}, {30'd0, done, busy}, 32'd0);
   endtask

   task automatic do_call(input logic [2:0] f, input logic [7:0] fl, input bit inj);
      logic [15:0] tgt, ra;
      bit tk;
      int wc;
      tgt = 16'h0800 + 16'(n_tgt * 8);
      n_tgt++;
      mem[a12(pc_m + 16'd1)] = tgt[7:0];
      mem[a12(pc_m + 16'd2)] = tgt[15:8];
      tk = cond_ok(f, fl);
      wc = wr_cnt;
      ra = pc_m + 16'd3;
      run_op(2'b00, f, fl, tk ? 17 : 10, inj, "call");
      if (tk) begin
         chk("R3 high byte at SP-1", 32'(mem[a12(sp_m - 16'd1)]), 32'(ra[15:8]));
         chk("R3 low byte at SP-2", 32'(mem[a12(sp_m - 16'd2)]), 32'(ra[7:0]));
         chk("R3 two writes", 32'(wr_cnt - wc), 32'd2);
         pc_m = tgt;
         sp_m = sp_m - 16'd2;
      end else begin
         chk("R4 no write", 32'(wr_cnt - wc), 32'd0);
         pc_m = pc_m + 16'd3;
      end
      chk(tk ? "R2 R3 pc after call" : "R2 R4 pc after call", 32'(pc), 32'(pc_m));
      chk(tk ? "R3 sp after call" : "R4 sp after call", 32'(sp), 32'(sp_m));
   endtask

   task automatic do_retc(input logic [2:0] f, input logic [7:0] fl);
      bit tk;
      int wc;
      tk = cond_ok(f, fl);
      wc = wr_cnt;
      run_op(2'b10, f, fl, tk ? 11 : 5, 1'b0, "ret cc");
      if (tk) begin
         pc_m = {mem[a12(sp_m + 16'd1)], mem[a12(sp_m)]};
         sp_m = sp_m + 16'd2;
      end else begin
         pc_m = pc_m + 16'd1;
      end
      chk("R6 no write", 32'(wr_cnt - wc), 32'd0);
      chk("R2 R6 pc after ret cc", 32'(pc), 32'(pc_m));
      chk("R6 sp after ret cc", 32'(sp), 32'(sp_m));
   endtask

   task automatic do_ret(input logic [15:0] exp_pc);
      run_op(2'b01, 3'd0, 8'h00, 10, 1'b0, "ret");
      pc_m = {mem[a12(sp_m + 16'd1)], mem[a12(sp_m)]};
      sp_m = sp_m + 16'd2;
      chk("R5 pc from stack", 32'(pc), 32'(exp_pc));
      chk("R5 pc matches bytes", 32'(pc), 32'(pc_m));
      chk("R5 sp raised", 32'(sp), 32'(sp_m));
   endtask

   task automatic do_rst(input logic [2:0] f);
      logic [15:0] ra;
      ra = pc_m + 16'd1;
      run_op(2'b11, f, 8'hFF, 11, 1'b0, "restart");
      chk("R7 pushed high", 32'(mem[a12(sp_m - 16'd1)]), 32'(ra[15:8]));
      chk("R7 pushed low", 32'(mem[a12(sp_m - 16'd2)]), 32'(ra[7:0]));
      sp_m = sp_m - 16'd2;
      pc_m = 16'(f) * 16'd8;
      chk("R7 vector", 32'(pc), 32'(pc_m));
      chk("R7 sp lowered", 32'(sp), 32'(sp_m));
      do_ret(ra);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [15:0] back;
      logic [7:0]  fl;
      for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
      start = 1'b0; op_i = 2'b00; fld_i = 3'd0; flags_i = 8'h00;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 pc reset", 32'(pc), 32'h0000);
      chk("R1 sp reset", 32'(sp), 32'hFFFF);
      chk("R1 tcount reset", 32'(tcount), 32'd0);
      chk("R1 idle", {30'd0, busy, done}, 32'd0);
      rst = 1'b0;
      pc_m = 16'h0000;
      sp_m = 16'hFFFF;

      // R10: stray start during a taken call, then return to the caller
      back = pc_m + 16'd3;
      do_call(3'd0, 8'h00, 1'b1);
      do_ret(back);

      // R2 sweep: every field with every combination of S, Z, P/V, C
      for (int f = 0; f < 8; f++) begin
         for (int k = 0; k < 16; k++) begin
            fl = {k[3], k[2], 3'b101, k[1], 1'b0, k[0]};
            do_call(3'(f), fl, 1'b0);
            do_retc(3'(f), fl);
         end
         do_rst(3'(f));
      end

      finish_run();
   end
endmodule